// File: doc/BRIEF.md
# In-Order Read Completion Buffer

This block holds read payloads of fixed size (512 beats of 128 bits, 8 KiB) that come back from a storage network in any order. The block gives them to the user in the order in which the read commands were issued. Each accepted read command gets one storage slot, chosen round-robin. The slot number goes with the command as its tag. Completion beats come back carrying that tag and a beat offset. Each beat is written straight to its place in the slot, so beats inside a payload may also arrive in any order.

A drain state machine watches the oldest outstanding slot, called the head. It has three states. WAIT holds until the head slot is occupied and has all 512 beats. WAIT then moves to STREAM. STREAM sends one beat per cycle while the registered pause is low. After the last beat it releases the slot and moves to GAP. GAP holds for a fixed two cycles and then returns to WAIT. The pause input goes through one register, and the output goes through one more. This gives a fixed two-cycle latency from the pause input to the valid output. The depth code sets the slot count (8 to 128 slots, 64 KiB to 1 MiB of storage). A slot's credit comes back in the same cycle its last beat is sent.

Top module: `rd_reorder_buf`

## Requirements
- R1: The parameter DEPTH_CODE (3 to 7) gives 2^DEPTH_CODE slots. cmd_ready is low exactly when that many commands are outstanding. A cmd_req raised while cmd_ready is low is ignored, and cmd_tag does not move.
- R2: Tags are handed out round-robin from 0 after reset. cmd_tag shows the tag that the next accepted command receives, and it steps by one (modulo the slot count) on each accepted cmd_req.
- R3: A fill beat with tag t and offset b is stored at slot t, beat b. A payload is sent in offset order 0 to 511, and each output beat carries the data written at that offset.
- R4: Payloads are sent in command-issue order, whatever order their slots are filled in.
- R5: No beat of a payload is sent before all 512 beats of its slot have been received.
- R6: Each payload is exactly 512 valid beats. While pause is low, these beats come on consecutive cycles.
- R7: rd_valid is low in any cycle whose cycle-minus-two had rd_pause high. Valid therefore drops two cycles after pause rises.
- R8: During a payload, rd_valid returns two cycles after rd_pause falls.
- R9: There are at least two cycles with rd_valid low between the last beat of one payload and the first beat of the next.
- R10: A slot is freed in the cycle its last beat is sent, and cmd_ready is high in that cycle.
- R11: After reset, rd_valid is 0, cmd_ready is 1 and cmd_tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req | input | 1 | Issue one read command (accepted when cmd_ready is high) |
| cmd_ready | output | 1 | A free slot exists |
| cmd_tag | output | DEPTH_CODE | Slot tag the next accepted command receives |
| fill_valid | input | 1 | A completion beat is present |
| fill_tag | input | DEPTH_CODE | Slot tag of the completion beat |
| fill_beat | input | 9 | Beat offset within the slot (0 to 511) |
| fill_data | input | 128 | Completion beat data |
| rd_pause | input | 1 | User not ready for read data |
| rd_valid | output | 1 | rd_data carries a payload beat |
| rd_data | output | 128 | Payload beat, sent in issue order |

## Verification
The bench fills slots in reverse and shuffled order, so a buffer that drained in fill order, or that wrote beats in arrival order, would give data from the wrong command or the wrong offset. One head slot is left one beat short for several cycles, to catch a drain that starts on a partial slot. Random pause pulses, including single-cycle ones, are applied during payloads. A pause path that is one register short or long breaks the exact two-cycle relation on every toggle. The bench also checks the idle run before each new payload and checks cmd_ready as credits return. A slot freed late or early shows up as a cmd_ready mismatch.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    typedef enum logic [1:0] {
        DR_WAIT   = 2'd0,
        DR_STREAM = 2'd1,
        DR_GAP    = 2'd2
    } drain_state_t;

    function automatic int slots_of(input int code);
        return 1 << code;
    endfunction

endpackage

// File: rtl/rcb_slot_alloc.sv
module rcb_slot_alloc #(
    parameter int SLOTS = 8,
    parameter int SW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic          release_i,
    output logic          alloc_ok,
    output logic [SW-1:0] tail,
    output logic [SW-1:0] head,
    output logic [SW:0]   occupied
);
    logic do_alloc;

    assign alloc_ok = (occupied != (SW+1)'(SLOTS));
    assign do_alloc = alloc_req && alloc_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail     <= '0;
            head     <= '0;
            occupied <= '0;
        end else begin
            if (do_alloc)  tail <= tail + 1'b1;
            if (release_i) head <= head + 1'b1;
            unique case ({do_alloc, release_i})
                2'b10:   occupied <= occupied + 1'b1;
                2'b01:   occupied <= occupied - 1'b1;
                default: occupied <= occupied;
            endcase
        end
    end
endmodule

// File: rtl/rcb_fill_track.sv
module rcb_fill_track #(
    parameter int SLOTS = 8,
    parameter int SW    = 3,
    parameter int BEATS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_valid,
    input  logic [SW-1:0]    fill_tag,
    input  logic             clear_i,
    input  logic [SW-1:0]    clear_tag,
    output logic [SLOTS-1:0] slot_full
);
    localparam int CW = $clog2(BEATS + 1);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (clear_i && clear_tag == SW'(s)) begin
                cnt <= '0;
            end else if (fill_valid && fill_tag == SW'(s)) begin
                cnt <= cnt + 1'b1;
            end
        end
        assign slot_full[s] = (cnt == CW'(BEATS));
    end
endmodule

// File: rtl/rcb_store.sv
module rcb_store #(
    parameter int AW = 12,
    parameter int DW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/rcb_drain_fsm.sv
module rcb_drain_fsm
    import rcb_pkg::*;
#(
    parameter int BEATS   = 512,
    parameter int BW      = 9,
    parameter int GAP_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_ready,
    input  logic          pause_i,
    output logic          fire,
    output logic          release_o,
    output logic [BW-1:0] beat_idx,
    output logic          valid_o
);
    localparam int            GW   = $clog2(GAP_CYC + 1);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    drain_state_t  state, state_nxt;
    logic          pause_q;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= DR_WAIT;
            pause_q  <= 1'b0;
            valid_o  <= 1'b0;
            beat_idx <= '0;
            gap_cnt  <= '0;
        end else begin
            state   <= state_nxt;
            pause_q <= pause_i;
            valid_o <= fire;
            if (release_o)  beat_idx <= '0;
            else if (fire)  beat_idx <= beat_idx + 1'b1;
            if (state == DR_GAP) gap_cnt <= gap_cnt + 1'b1;
            else                 gap_cnt <= '0;
        end
    end

    always_comb begin
        state_nxt = state;
        fire      = 1'b0;
        release_o = 1'b0;
        unique case (state)
            DR_WAIT: begin
                if (head_ready) state_nxt = DR_STREAM;
            end
            DR_STREAM: begin
                if (!pause_q) begin
                    fire = 1'b1;
                    if (beat_idx == LAST) begin
                        release_o = 1'b1;
                        state_nxt = DR_GAP;
                    end
                end
            end
            DR_GAP: begin
                if (gap_cnt == GW'(GAP_CYC - 1)) state_nxt = DR_WAIT;
            end
            default: state_nxt = DR_WAIT;
        endcase
    end
endmodule

// File: rtl/rd_reorder_buf.sv
module rd_reorder_buf #(
    parameter int DEPTH_CODE = 3,
    parameter int BEATS      = 512,
    parameter int DW         = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_req,
    output logic                  cmd_ready,
    output logic [DEPTH_CODE-1:0] cmd_tag,
    input  logic                  fill_valid,
    input  logic [DEPTH_CODE-1:0] fill_tag,
    input  logic [$clog2(BEATS)-1:0] fill_beat,
    input  logic [DW-1:0]         fill_data,
    input  logic                  rd_pause,
    output logic                  rd_valid,
    output logic [DW-1:0]         rd_data
);
    localparam int SLOTS = rcb_pkg::slots_of(DEPTH_CODE);
    localparam int SW    = DEPTH_CODE;
    localparam int BW    = $clog2(BEATS);
    localparam int AW    = SW + BW;

    logic [SW-1:0]    head;
    logic [SW:0]      occupied;
    logic [SLOTS-1:0] slot_full;
    logic             head_full;
    logic             head_ready;
    logic             fire;
    logic             release_s;
    logic [BW-1:0]    beat_idx;

    rcb_slot_alloc #(.SLOTS(SLOTS), .SW(SW)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (cmd_req),
        .release_i (release_s),
        .alloc_ok  (cmd_ready),
        .tail      (cmd_tag),
        .head      (head),
        .occupied  (occupied)
    );

    rcb_fill_track #(.SLOTS(SLOTS), .SW(SW), .BEATS(BEATS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_tag   (fill_tag),
        .clear_i    (release_s),
        .clear_tag  (head),
        .slot_full  (slot_full)
    );

    assign head_full  = slot_full[head];
    assign head_ready = head_full && (occupied != '0);

    rcb_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fill_valid),
        .waddr ({fill_tag, fill_beat}),
        .wdata (fill_data),
        .re    (fire),
        .raddr ({head, beat_idx}),
        .rdata (rd_data)
    );

    rcb_drain_fsm #(.BEATS(BEATS), .BW(BW), .GAP_CYC(2)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_ready (head_ready),
        .pause_i    (rd_pause),
        .fire       (fire),
        .release_o  (release_s),
        .beat_idx   (beat_idx),
        .valid_o    (rd_valid)
    );
endmodule

// File: rtl/rd_reorder_buf_chk.sv
module rd_reorder_buf_chk #(
    parameter int DEPTH_CODE = 3,
    parameter int BEATS      = 512
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_req,
    input logic                  cmd_ready,
    input logic [DEPTH_CODE-1:0] cmd_tag,
    input logic                  rd_pause,
    input logic                  rd_valid,
    input logic [DEPTH_CODE:0]   occupied,
    input logic                  head_full
);
    localparam int SLOTS = 1 << DEPTH_CODE;
    localparam int BW    = $clog2(BEATS);

    logic [1:0]    age;
    logic [BW-1:0] beat_cnt;
    logic [1:0]    idle_run;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age      <= '0;
            beat_cnt <= '0;
            idle_run <= '0;
            seen     <= 1'b0;
        end else begin
            if (age != 2'd3) age <= age + 1'b1;
            if (rd_valid) begin
                beat_cnt <= beat_cnt + 1'b1;
                idle_run <= '0;
                if (beat_cnt == BW'(BEATS - 1)) seen <= 1'b1;
            end else if (idle_run != 2'd3) begin
                idle_run <= idle_run + 1'b1;
            end
        end
    end

    p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        occupied <= (DEPTH_CODE+1)'(SLOTS));

    p_hold_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> cmd_tag == $past(cmd_tag));

    p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_ready) |=> cmd_tag == DEPTH_CODE'($past(cmd_tag) + 1'b1));

    p_full_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && age != 2'd0) |-> $past(head_full));

    p_pause_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && age >= 2'd2) |-> !$past(rd_pause, 2));

    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && beat_cnt == '0 && seen) |-> idle_run >= 2'd2);
endmodule

bind rd_reorder_buf rd_reorder_buf_chk #(.DEPTH_CODE(DEPTH_CODE), .BEATS(BEATS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_req   (cmd_req),
    .cmd_ready (cmd_ready),
    .cmd_tag   (cmd_tag),
    .rd_pause  (rd_pause),
    .rd_valid  (rd_valid),
    .occupied  (occupied),
    .head_full (head_full)
);

// File: tb/sim_rd_reorder_buf.sv
module sim_rd_reorder_buf;
    localparam int DC    = 3;
    localparam int SLOTS = 8;
    localparam int BEATS = 512;
    localparam int NCMD  = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_req = 1'b0;
    logic         cmd_ready;
    logic [2:0]   cmd_tag;
    logic         fill_valid = 1'b0;
    logic [2:0]   fill_tag = '0;
    logic [8:0]   fill_beat = '0;
    logic [127:0] fill_data = '0;
    logic         rd_pause = 1'b0;
    logic         rd_valid;
    logic [127:0] rd_data;

    int checks = 0;
    int errors = 0;
    int n_iss = 0;
    int n_fill = 0;
    int acc_cnt = 0;
    int mon_seq = 0;
    int mon_beat = 0;
    int idle = 0;
    bit pause_en = 1'b0;
    bit done = 1'b0;
    logic [1:0] ph = '0;
    bit filled [NCMD+1];
    int slot_seq [SLOTS];

    always #10 clk = ~clk;

    rd_reorder_buf #(.DEPTH_CODE(DC), .BEATS(BEATS), .DW(128)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_ready(cmd_ready),
        .cmd_tag(cmd_tag), .fill_valid(fill_valid), .fill_tag(fill_tag),
        .fill_beat(fill_beat), .fill_data(fill_data), .rd_pause(rd_pause),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [127:0] pay(input int seq, input int beat);
        logic [31:0] s = seq;
        logic [31:0] b = beat;
        return {s ^ 32'hA5A50000, b, s * 32'h9E3779B1 + b * 32'h85EBCA6B, ~b ^ s};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        ph <= {ph[0], rd_pause};
        if (rst_n && cmd_req && cmd_ready) acc_cnt <= acc_cnt + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_beat > 0)
                chk(rd_valid == !ph[1], "R7 R8 pause latency", 128'(rd_valid), 128'(!ph[1]));
            if (rd_valid) begin
                if (mon_beat == 0) begin
                    chk(filled[mon_seq], "R5 drain before full", 0, 1);
                    if (mon_seq > 0) chk(idle >= 2, "R9 gap", 128'(idle), 2);
                end
                chk(rd_data == pay(mon_seq, mon_beat), "R3 R4 data/order",
                    rd_data, pay(mon_seq, mon_beat));
                idle = 0;
                mon_beat++;
                if (mon_beat == BEATS) begin
                    mon_beat = 0;
                    mon_seq++;
                end
            end else begin
                idle++;
            end
            chk(cmd_ready == ((acc_cnt - mon_seq) < SLOTS), "R10 credit",
                128'(cmd_ready), 128'((acc_cnt - mon_seq) < SLOTS));
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (pause_en && ($urandom % 6 == 0)) rd_pause = ~rd_pause;
            else if (!pause_en) rd_pause = 1'b0;
        end
    end

    task automatic issue_one();
        chk(cmd_tag == 3'(n_iss % SLOTS), "R2 tag order", 128'(cmd_tag), 128'(n_iss % SLOTS));
        slot_seq[cmd_tag] = n_iss;
        cmd_req = 1'b1;
        @(negedge clk);
        cmd_req = 1'b0;
        n_iss++;
    endtask

    task automatic fill_range(input int tag, input int lo, input int hi,
                              input int stride, input int off);
        int seq = slot_seq[tag];
        for (int i = lo; i < hi; i++) begin
            int b = (i * stride + off) % BEATS;
            fill_valid = 1'b1;
            fill_tag   = 3'(tag);
            fill_beat  = 9'(b);
            fill_data  = pay(seq, b);
            @(negedge clk);
        end
        fill_valid = 1'b0;
        if (hi == BEATS) begin
            filled[seq] = 1'b1;
            n_fill++;
        end
    endtask

    initial begin
        int seed_dummy;
        bit quiet;
        seed_dummy = $urandom(32'd1234);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R11 reset valid", 128'(rd_valid), 0);
        chk(cmd_ready == 1'b1, "R11 reset ready", 128'(cmd_ready), 1);
        chk(cmd_tag == 3'd0, "R11 reset tag", 128'(cmd_tag), 0);

        for (int i = 0; i < SLOTS; i++) issue_one();
        chk(!cmd_ready, "R1 ready low at capacity", 128'(cmd_ready), 0);
        cmd_req = 1'b1;
        repeat (3) @(negedge clk);
        cmd_req = 1'b0;
        chk(cmd_tag == 3'd0, "R1 ignored request tag", 128'(cmd_tag), 0);
        chk(!cmd_ready, "R1 ignored request ready", 128'(cmd_ready), 0);

        pause_en = 1'b1;
        for (int t = SLOTS - 1; t >= 1; t--) fill_range(t, 0, BEATS, 2 * t + 1, t * 37);
        chk(!rd_valid, "R4 no drain while head empty", 128'(rd_valid), 0);
        fill_range(0, 0, BEATS - 1, 173, 5);
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (rd_valid) quiet = 1'b0;
        end
        chk(quiet, "R5 head short one beat", 128'(!quiet), 0);
        fill_range(0, BEATS - 1, BEATS, 173, 5);

        while (n_iss < NCMD || n_fill < n_iss) begin
            if (n_iss < NCMD && cmd_ready && ($urandom % 2 == 0 || n_fill == n_iss)) begin
                issue_one();
            end else if (n_fill < n_iss) begin
                int pick = $urandom % (n_iss - n_fill);
                for (int s = 0; s < n_iss; s++) begin
                    if (!filled[s]) begin
                        if (pick == 0) begin
                            fill_range(s % SLOTS, 0, BEATS, 2 * ($urandom % 200) + 1,
                                       $urandom % BEATS);
                            break;
                        end
                        pick--;
                    end
                end
            end else begin
                @(negedge clk);
            end
        end
        while (mon_seq < NCMD) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(mon_seq == NCMD, "R6 payload count", 128'(mon_seq), NCMD);
        chk(mon_beat == 0, "R6 whole payloads", 128'(mon_beat), 0);
        chk(cmd_ready, "R10 all credits back", 128'(cmd_ready), 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog act=%0d exp=%0d", mon_seq, NCMD);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule